// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Segment

This block places a boundary-scan cell on each of a group of bidirectional digital pins. It sits between the core's port logic and the pads. The core side carries output data, output enable and pull-up enable. The pad side carries pad input, pad output, pad output enable and pad pull-up. Each pin owns only two scan stages. A control stage holds the output enable. A data stage serves both the driven output value and the observed input value. The stages of neighbouring pins link into one serial path from `scan_in` to `scan_out`.

A test access controller, which is not part of this block, supplies the mode code and three single-cycle strobes: capture, shift and update. All of them act on the rising edge of `tck`. In functional mode, the pads follow the core. In observe mode, the pads still follow the core while the chain samples and preloads; the update latches load but stay away from the pads. In drive mode, the update latches own the pad output and output enable. The pull-up is held off in both test modes. The pad input always reaches the core unsynchronised.

Top module: `bidir_bscan_segment`

## Requirements
- R1: An active-low `trst_n` clears every scan stage and every update latch to 0. With all core inputs at 0, every pad output reads 0 in each mode and `scan_out` reads 0.
- R2: For mode codes 2'b00 (functional) and 2'b11 (spare), `pad_oe`, `pad_do` and `pad_pu` equal `core_oe`, `core_do` and `core_pue` bit for bit, in the same cycle.
- R3: `core_di` equals `pad_di` in every mode, combinationally, with no register in the path.
- R4: On a clock edge with `capture_dr` high, the control stage of pin i loads `core_oe[i]` and the data stage of pin i loads `pad_di[i]`.
- R5: On a clock edge with `shift_dr` high, the serial order is `scan_in`, then pin 0 control, pin 0 data, pin 1 control, pin 1 data, and so on. `scan_out` presents the data stage of the last pin.
- R6: When `capture_dr` and `shift_dr` are both high on the same edge, the capture takes effect and the shift does not.
- R7: The update latches of each pin load the current contents of both stages on an edge with `update_dr` high. They hold their value on every other edge, whatever the shift and capture strobes do.
- R8: In mode code 2'b01 (observe), `pad_oe` and `pad_do` follow the core and `pad_pu` is 0, whatever the update latches hold.
- R9: In mode code 2'b10 (drive), `pad_oe[i]` equals the control update latch of pin i, `pad_do[i]` equals the data update latch of pin i, and `pad_pu` is 0.
- R10: When `update_dr` and `shift_dr` are high on the same edge, the update latches receive the stage contents from before that edge's shift, and the chain still shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all stages and latches act on its rising edge |
| trst_n | input | 1 | Active-low asynchronous reset of stages and latches |
| mode | input | 2 | 00 functional, 01 observe, 10 drive, 11 spare (acts as functional) |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| scan_in | input | 1 | Serial input into pin 0's control stage |
| scan_out | output | 1 | Serial output from the last pin's data stage |
| core_oe | input | NUM_PINS | Output enable from core port logic |
| core_do | input | NUM_PINS | Output data from core port register |
| core_pue | input | NUM_PINS | Pull-up enable from core port logic |
| core_di | output | NUM_PINS | Pad input returned to the core |
| pad_di | input | NUM_PINS | Value seen on the pad |
| pad_do | output | NUM_PINS | Value driven toward the pad |
| pad_oe | output | NUM_PINS | Pad output driver enable |
| pad_pu | output | NUM_PINS | Pad pull-up enable |

## Verification
Two pairs of functions can land on the same edge. An update can coincide with a shift, and a capture can coincide with a shift. The bench loads a known pattern into the chain, then raises update and shift together for one edge. It checks that the pad outputs in drive mode carry the pre-shift pattern, and that the chain read back afterwards carries the shifted pattern. Capture and shift are raised together over a preloaded chain, and the pass condition is that the read-back shows only the captured pin values.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
   typedef enum logic [1:0] {
      BS_FUNC    = 2'b00,
      BS_OBSERVE = 2'b01,
      BS_DRIVE   = 2'b10,
      BS_SPARE   = 2'b11
   } bs_mode_e;

   localparam int unsigned STAGES_PER_PIN = 2;
endpackage

// File: rtl/bscan_pin_stages.sv
module bscan_pin_stages (
   input  logic clk,
   input  logic rst_n,
   input  logic capture_en,
   input  logic shift_en,
   input  logic update_en,
   input  logic sin,
   input  logic cap_ctl,
   input  logic cap_dat,
   output logic sout,
   output logic upd_ctl,
   output logic upd_dat
);
   logic ctl_q;
   logic dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= 1'b0;
         dat_q <= 1'b0;
      end else if (capture_en) begin
         ctl_q <= cap_ctl;
         dat_q <= cap_dat;
      end else if (shift_en) begin
         ctl_q <= sin;
         dat_q <= ctl_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_ctl <= 1'b0;
         upd_dat <= 1'b0;
      end else if (update_en) begin
         upd_ctl <= ctl_q;
         upd_dat <= dat_q;
      end
   end

   assign sout = dat_q;

   // R4
   capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture_en |=> (ctl_q == $past(cap_ctl)) && (dat_q == $past(cap_dat)));

   // R5
   shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !capture_en) |=> (ctl_q == $past(sin)) && (dat_q == $past(ctl_q)));

   // R7
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !update_en |=> $stable(upd_ctl) && $stable(upd_dat));

   // R10
   update_presift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      update_en |=> (upd_ctl == $past(ctl_q)) && (upd_dat == $past(dat_q)));
endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
   import bscan_pkg::*;
#(
   parameter bit HAS_PULLUP = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  bs_mode_e mode,
   input  logic     core_oe,
   input  logic     core_do,
   input  logic     core_pue,
   input  logic     upd_ctl,
   input  logic     upd_dat,
   output logic     pad_oe,
   output logic     pad_do,
   output logic     pad_pu
);
   logic drive_sel;
   logic test_active;

   assign drive_sel   = (mode == BS_DRIVE);
   assign test_active = (mode == BS_DRIVE) || (mode == BS_OBSERVE);

   always_comb begin
      if (drive_sel) begin
         pad_oe = upd_ctl;
         pad_do = upd_dat;
      end else begin
         pad_oe = core_oe;
         pad_do = core_do;
      end
   end

   generate
      if (HAS_PULLUP) begin : g_pullup
         assign pad_pu = core_pue & ~test_active;
      end else begin : g_no_pullup
         logic unused_pue;
         assign unused_pue = core_pue;
         assign pad_pu     = 1'b0;
      end
   endgenerate

   // R8
   pullup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BS_OBSERVE || mode == BS_DRIVE) |-> !pad_pu);

   // R8
   observe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BS_OBSERVE) |-> (pad_oe == core_oe) && (pad_do == core_do));

   // R9
   drive_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BS_DRIVE) |-> (pad_oe == upd_ctl) && (pad_do == upd_dat));
endmodule

// File: rtl/bidir_bscan_segment.sv
module bidir_bscan_segment
   import bscan_pkg::*;
#(
   parameter int unsigned NUM_PINS   = 2,
   parameter bit          HAS_PULLUP = 1'b1
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic [1:0]          mode,
   input  logic                capture_dr,
   input  logic                shift_dr,
   input  logic                update_dr,
   input  logic                scan_in,
   output logic                scan_out,
   input  logic [NUM_PINS-1:0] core_oe,
   input  logic [NUM_PINS-1:0] core_do,
   input  logic [NUM_PINS-1:0] core_pue,
   output logic [NUM_PINS-1:0] core_di,
   input  logic [NUM_PINS-1:0] pad_di,
   output logic [NUM_PINS-1:0] pad_do,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu
);
   localparam int unsigned CHAIN_LEN = NUM_PINS * STAGES_PER_PIN;

   generate
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("bidir_bscan_segment: NUM_PINS must be at least 1");
      end
      if (CHAIN_LEN != 2 * NUM_PINS) begin : g_bad_len
         $error("bidir_bscan_segment: each pin needs exactly two stages");
      end
   endgenerate

   bs_mode_e            mode_e;
   logic [NUM_PINS:0]   link;
   logic [NUM_PINS-1:0] upd_ctl;
   logic [NUM_PINS-1:0] upd_dat;

   assign mode_e   = bs_mode_e'(mode);
   assign link[0]  = scan_in;
   assign scan_out = link[NUM_PINS];
   assign core_di  = pad_di;

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         bscan_pin_stages u_stages (
            .clk        (tck),
            .rst_n      (trst_n),
            .capture_en (capture_dr),
            .shift_en   (shift_dr),
            .update_en  (update_dr),
            .sin        (link[i]),
            .cap_ctl    (core_oe[i]),
            .cap_dat    (pad_di[i]),
            .sout       (link[i+1]),
            .upd_ctl    (upd_ctl[i]),
            .upd_dat    (upd_dat[i])
         );

         bscan_pad_mux #(
            .HAS_PULLUP (HAS_PULLUP)
         ) u_mux (
            .clk      (tck),
            .rst_n    (trst_n),
            .mode     (mode_e),
            .core_oe  (core_oe[i]),
            .core_do  (core_do[i]),
            .core_pue (core_pue[i]),
            .upd_ctl  (upd_ctl[i]),
            .upd_dat  (upd_dat[i]),
            .pad_oe   (pad_oe[i]),
            .pad_do   (pad_do[i]),
            .pad_pu   (pad_pu[i])
         );
      end
   endgenerate

   // R2
   func_pass_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (mode_e == BS_FUNC || mode_e == BS_SPARE) |->
         (pad_oe == core_oe) && (pad_do == core_do) && (pad_pu == (HAS_PULLUP ? core_pue : '0)));

   // R3
   input_return_chk: assert property (@(posedge tck) disable iff (!trst_n)
      core_di == pad_di);
endmodule

// File: tb/tb_bidir_bscan_segment.sv
module tb_bidir_bscan_segment;
   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       capture_dr = 1'b0;
   logic       shift_dr = 1'b0;
   logic       update_dr = 1'b0;
   logic       scan_in = 1'b0;
   logic       scan_out;
   logic [1:0] core_oe = '0, core_do = '0, core_pue = '0, pad_di = '0;
   logic [1:0] core_di, pad_do, pad_oe, pad_pu;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 tck = ~tck;

   bidir_bscan_segment dut (
      .tck(tck), .trst_n(trst_n), .mode(mode),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
      .scan_in(scan_in), .scan_out(scan_out),
      .core_oe(core_oe), .core_do(core_do), .core_pue(core_pue), .core_di(core_di),
      .pad_di(pad_di), .pad_do(pad_do), .pad_oe(pad_oe), .pad_pu(pad_pu)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // stage k of pattern p: k=0 pin0 ctl, 1 pin0 dat, 2 pin1 ctl, 3 pin1 dat
   task automatic shift_in(input logic [3:0] p);
      for (int t = 0; t < 4; t++) begin
         @(negedge tck);
         scan_in  = p[3-t];
         shift_dr = 1'b1;
      end
      @(negedge tck);
      shift_dr = 1'b0;
      scan_in  = 1'b0;
   endtask

   task automatic shift_out(output logic [3:0] got);
      for (int t = 0; t < 4; t++) begin
         @(negedge tck);
         got[3-t] = scan_out;
         shift_dr = (t < 3);
      end
   endtask

   task automatic strobe_update();
      @(negedge tck); update_dr = 1'b1;
      @(negedge tck); update_dr = 1'b0;
   endtask

   task automatic strobe_capture();
      @(negedge tck); capture_dr = 1'b1;
      @(negedge tck); capture_dr = 1'b0;
   endtask

   task automatic chk_drive(input string req, input logic [3:0] l);
      mode = 2'b10;
      #1;
      chk(req, {30'd0, pad_oe}, {30'd0, l[2], l[0]});
      chk(req, {30'd0, pad_do}, {30'd0, l[3], l[1]});
      chk(req, {30'd0, pad_pu}, 32'd0);
   endtask

   initial begin
      logic [3:0] got;
      logic [3:0] latch;
      repeat (3) @(negedge tck);
      trst_n = 1'b1;
      @(negedge tck);

      // R1 reset state
      for (int m = 0; m < 4; m++) begin
         mode = m[1:0];
         #1;
         chk("R1", {26'd0, pad_oe, pad_do, pad_pu}, 32'd0);
         chk("R1", {31'd0, scan_out}, 32'd0);
      end

      // R4 R5 capture sweep
      for (int c = 0; c < 16; c++) begin
         mode = 2'b00;
         core_oe = c[1:0];
         pad_di  = c[3:2];
         strobe_capture();
         shift_out(got);
         chk("R4", {28'd0, got}, {28'd0, pad_di[1], core_oe[1], pad_di[0], core_oe[0]});
      end

      // R5 R7 R9 load, hold and drive
      latch = 4'h0;
      for (int p = 0; p < 16; p++) begin
         mode = 2'b00;
         shift_in(p[3:0]);
         chk_drive("R7", latch);
         strobe_update();
         latch = p[3:0];
         chk_drive("R9", latch);
         shift_out(got);
         chk("R5", {28'd0, got}, {28'd0, p[3:0]});
         chk_drive("R7", latch);
      end

      // R2 R3 R8 R9 mode sweep with latches holding 0110
      mode = 2'b00;
      shift_in(4'b0110);
      strobe_update();
      latch = 4'b0110;
      for (int m = 0; m < 4; m++) begin
         for (int v = 0; v < 256; v++) begin
            mode     = m[1:0];
            core_oe  = v[1:0];
            core_do  = v[3:2];
            core_pue = v[5:4];
            pad_di   = v[7:6];
            #1;
            chk("R3", {30'd0, core_di}, {30'd0, v[7:6]});
            if (m == 2) begin
               chk("R9", {28'd0, pad_oe, pad_do}, {28'd0, latch[2], latch[0], latch[3], latch[1]});
               chk("R9", {30'd0, pad_pu}, 32'd0);
            end else if (m == 1) begin
               chk("R8", {28'd0, pad_oe, pad_do}, {28'd0, v[1:0], v[3:2]});
               chk("R8", {30'd0, pad_pu}, 32'd0);
            end else begin
               chk("R2", {26'd0, pad_oe, pad_do, pad_pu}, {26'd0, v[1:0], v[3:2], v[5:4]});
            end
         end
      end

      // R6 capture wins over shift
      mode = 2'b00;
      core_oe = 2'b01;
      pad_di  = 2'b10;
      shift_in(4'b0110);
      @(negedge tck);
      capture_dr = 1'b1; shift_dr = 1'b1; scan_in = 1'b1;
      @(negedge tck);
      capture_dr = 1'b0; shift_dr = 1'b0; scan_in = 1'b0;
      shift_out(got);
      chk("R6", {28'd0, got}, 32'b1001);

      // R10 update and shift on the same edge
      mode = 2'b00;
      shift_in(4'b0000);
      strobe_update();
      shift_in(4'b1011);
      @(negedge tck);
      shift_dr = 1'b1; update_dr = 1'b1; scan_in = 1'b0;
      @(negedge tck);
      shift_dr = 1'b0; update_dr = 1'b0;
      chk_drive("R10", 4'b1011);
      mode = 2'b00;
      shift_out(got);
      chk("R10", {28'd0, got}, 32'b0110);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge tck);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule